// File: doc/BRIEF.md
# Write Burst Beat, Strobe and Response Order Monitor

This block watches the write address, write data and write response channels of a memory-mapped burst bus. It does not drive the bus. For each accepted write address it keeps the burst length, the byte offset of the start address, the transfer size and the burst type in a small queue of parameterised depth. Data beats are matched in order to the oldest address still waiting for data. The block counts the beats of each burst, checks where the last-beat marker falls, and checks each beat's byte strobes against the lanes that the address, size and beat index allow.

Data may run ahead of its address. Beats seen while no address is waiting go into the beat counter as early data. When the address later leaves the queue, the block either resolves a finished early burst against that address's length, or picks up a partial early burst at the correct beat index. On the response channel the block flags a response that starts before its transaction has both an accepted address and an accepted last beat. It also checks that payloads hold while a transfer is stalled, that each valid is held until ready, and that both valids are low in the first cycle after reset. Two sticky flags report when its own tracking overflows or underflows.

Protocol error flags are one-cycle pulses. The two tracking flags stay set until reset.

Top module: `wr_order_monitor`

## Requirements
- R1: A data beat accepted with the last marker set, at a beat index that differs from the burst length field (the length field is the number of beats minus one), pulses `err_beats`.
- R2: A data beat accepted with the last marker clear, at a beat index equal to the length field, pulses `err_beats`. Counting goes on, so a later last beat at a higher index pulses it again.
- R3: Beats accepted while no address is waiting count as early data. If the early burst already ended with a last beat, then in the cycle after its address is queued `err_beats` pulses exactly when the early beat count is not the length field plus one. If the early burst is still open, the next beats continue at the early beat index for both the count check and the strobe check.
- R4: The bus has B byte lanes. Let a be the start address modulo B, s = 2^size, and al = a rounded down to a multiple of s. For the first beat of a FIXED (code 0) or INCR (code 1) burst, only lanes a through al + min(s,B) - 1 may carry strobes. Any other set strobe bit pulses `err_strobe`. A beat with no strobe bits set is always legal.
- R5: For beat k ≥ 1 of an INCR burst, the legal lanes run from L = (al + k·s) mod B through L + min(s,B) - 1.
- R6: Every beat of a FIXED burst uses the first-beat lanes of R4. WRAP (code 2) and the reserved code 3 get no strobe check.
- R7: A response starts when the response valid is high and no response was stalled in the cycle before. A start pulses `err_early_resp` if, counting only handshakes completed in earlier cycles, there is no address or no last data beat that a previous response has not already used.
- R8: While a data beat is stalled (valid high, ready low), any change of data, strobes, last marker or user bits in the next cycle, or valid dropping, pulses `err_w_hold`.
- R9: While a response is stalled, any change of ID, response code or user bits in the next cycle, or valid dropping, pulses `err_b_hold`.
- R10: Data valid or response valid high in the first clock cycle after reset is released pulses `err_reset_valid`.
- R11: An address accepted while DEPTH addresses are already queued and none leaves in that cycle sets `trk_overflow`. So does a data beat arriving after a finished early burst while no address is queued. The flag stays set until reset.
- R12: A response start when no address is outstanding sets `trk_underflow`, which stays set until reset.
- R13: During and right after reset, all eight outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr_lo | input | log2(DATA_W/8) | Byte-offset bits of the write address |
| aw_len | input | 8 | Burst length minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | Burst type: 0 FIXED, 1 INCR, 2 WRAP |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Last beat marker |
| w_user | input | USER_W | Write data user bits |
| b_valid | input | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_id | input | ID_W | Response ID |
| b_resp | input | 2 | Response code |
| b_user | input | USER_W | Response user bits |
| err_beats | output | 1 | Beat count or last placement error pulse |
| err_strobe | output | 1 | Illegal strobe lane pulse |
| err_early_resp | output | 1 | Response before address and last beat pulse |
| err_w_hold | output | 1 | Data channel stall stability error pulse |
| err_b_hold | output | 1 | Response channel stall stability error pulse |
| err_reset_valid | output | 1 | Valid high in first cycle after reset pulse |
| trk_overflow | output | 1 | Sticky: tracking capacity exceeded |
| trk_underflow | output | 1 | Sticky: response with nothing outstanding |

## Verification
Every error flag is registered, so a violation seen at one rising edge shows on the outputs just after that edge. The bench drives each transfer for a single cycle from a falling edge and reads the flags at the next falling edge, which isolates the pulse of exactly that transfer. Early-data resolution is the only result that comes one cycle later: it happens in the cycle after the address enters the queue, so the bench waits one extra falling edge after the address handshake before it reads `err_beats`. The sticky tracking flags are read right after the event that sets them and again a few cycles later to confirm that they stay set.

// File: rtl/wr_order_monitor.sv
module wr_order_monitor #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int USER_W = 2,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             aw_valid,
  input  logic                             aw_ready,
  input  logic [$clog2(DATA_W/8)-1:0]      aw_addr_lo,
  input  logic [7:0]                       aw_len,
  input  logic [2:0]                       aw_size,
  input  logic [1:0]                       aw_burst,
  input  logic                             w_valid,
  input  logic                             w_ready,
  input  logic [DATA_W-1:0]                w_data,
  input  logic [DATA_W/8-1:0]              w_strb,
  input  logic                             w_last,
  input  logic [USER_W-1:0]                w_user,
  input  logic                             b_valid,
  input  logic                             b_ready,
  input  logic [ID_W-1:0]                  b_id,
  input  logic [1:0]                       b_resp,
  input  logic [USER_W-1:0]                b_user,
  output logic                             err_beats,
  output logic                             err_strobe,
  output logic                             err_early_resp,
  output logic                             err_w_hold,
  output logic                             err_b_hold,
  output logic                             err_reset_valid,
  output logic                             trk_overflow,
  output logic                             trk_underflow
);

  localparam int NB = DATA_W / 8;
  localparam int LB = $clog2(NB);
  localparam int QW = $clog2(DEPTH);

  logic aw_hs, w_hs;
  assign aw_hs = aw_valid & aw_ready;
  assign w_hs  = w_valid & w_ready;

  // address queue
  logic [7:0]    q_len   [DEPTH];
  logic [LB-1:0] q_lo    [DEPTH];
  logic [2:0]    q_size  [DEPTH];
  logic [1:0]    q_burst [DEPTH];
  logic [QW-1:0] wp, rp;
  logic [QW:0]   qn;
  logic          q_empty, q_full;

  assign q_empty = (qn == '0);
  assign q_full  = (qn == (QW+1)'(DEPTH));

  // data tracker
  logic          cur_valid;
  logic [7:0]    cur_len;
  logic [LB-1:0] cur_lo;
  logic [2:0]    cur_size;
  logic [1:0]    cur_burst;
  logic [8:0]    beat_cnt;
  logic          early_done;

  logic from_q, resolve, take_q, pop, push, ovf_aw, ovf_w;
  logic ctx_beat, early_beat;

  assign from_q     = !cur_valid && !q_empty;
  assign resolve    = from_q && early_done;
  assign take_q     = from_q && !early_done && w_hs;
  assign pop        = resolve || take_q;
  assign push       = aw_hs && (!q_full || pop);
  assign ovf_aw     = aw_hs && q_full && !pop;
  assign ctx_beat   = w_hs && (cur_valid || take_q);
  assign early_beat = w_hs && !cur_valid && !take_q;
  assign ovf_w      = early_beat && early_done && !resolve;

  logic [7:0]    c_len;
  logic [LB-1:0] c_lo;
  logic [2:0]    c_size;
  logic [1:0]    c_burst;

  assign c_len   = cur_valid ? cur_len   : q_len[rp];
  assign c_lo    = cur_valid ? cur_lo    : q_lo[rp];
  assign c_size  = cur_valid ? cur_size  : q_size[rp];
  assign c_burst = cur_valid ? cur_burst : q_burst[rp];

  logic       last_at, cnt_bad_beat, cnt_bad_res;
  logic [8:0] beat_nxt;

  assign last_at      = (beat_cnt == {1'b0, c_len});
  assign cnt_bad_beat = ctx_beat && (w_last != last_at);
  assign cnt_bad_res  = resolve && (beat_cnt != ({1'b0, q_len[rp]} + 9'd1));
  assign beat_nxt     = (beat_cnt == '1) ? beat_cnt : beat_cnt + 9'd1;

  // legal byte lanes for the current beat
  logic [NB-1:0] lane_ok;
  always_comb begin
    int sz, a0, al, base, lo, span;
    sz   = 1 << c_size;
    a0   = int'(c_lo);
    al   = a0 & ~(sz - 1);
    span = (sz < NB) ? sz : NB;
    if (beat_cnt == '0 || c_burst == 2'b00) begin
      lo   = a0;
      base = al;
    end else begin
      base = (al + int'(beat_cnt) * sz) & (NB - 1);
      lo   = base;
    end
    for (int j = 0; j < NB; j++)
      lane_ok[j] = (j >= lo) && (j < base + span);
  end

  logic strb_bad;
  assign strb_bad = ctx_beat && !c_burst[1] && |(w_strb & ~lane_ok);

  // response ordering
  logic             b_hold, w_hold, first_cyc, b_start;
  logic [CNT_W-1:0] aw_ahead, w_ahead;
  assign b_start = b_valid && !b_hold;

  logic aw_inc, aw_dec, wl_inc, wl_dec;
  assign aw_inc = aw_hs && (aw_ahead != '1);
  assign aw_dec = b_start && (aw_ahead != '0);
  assign wl_inc = w_hs && w_last && (w_ahead != '1);
  assign wl_dec = b_start && (w_ahead != '0);

  // stall capture
  logic [DATA_W-1:0]   wd_q;
  logic [DATA_W/8-1:0] ws_q;
  logic                wl_q;
  logic [USER_W-1:0]   wu_q;
  logic [ID_W-1:0]     bi_q;
  logic [1:0]          br_q;
  logic [USER_W-1:0]   bu_q;

  logic w_moved, b_moved;
  assign w_moved = (w_data != wd_q) || (w_strb != ws_q) || (w_last != wl_q) || (w_user != wu_q);
  assign b_moved = (b_id != bi_q) || (b_resp != br_q) || (b_user != bu_q);

  always_ff @(posedge clk) begin
    if (push) begin
      q_len[wp]   <= aw_len;
      q_lo[wp]    <= aw_addr_lo;
      q_size[wp]  <= aw_size;
      q_burst[wp] <= aw_burst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; qn <= '0;
      cur_valid <= 1'b0; cur_len <= '0; cur_lo <= '0; cur_size <= '0; cur_burst <= '0;
      beat_cnt <= '0; early_done <= 1'b0;
      aw_ahead <= '0; w_ahead <= '0;
      w_hold <= 1'b0; b_hold <= 1'b0; first_cyc <= 1'b1;
      wd_q <= '0; ws_q <= '0; wl_q <= 1'b0; wu_q <= '0;
      bi_q <= '0; br_q <= '0; bu_q <= '0;
      err_beats <= 1'b0; err_strobe <= 1'b0; err_early_resp <= 1'b0;
      err_w_hold <= 1'b0; err_b_hold <= 1'b0; err_reset_valid <= 1'b0;
      trk_overflow <= 1'b0; trk_underflow <= 1'b0;
    end else begin
      if (push) wp <= (wp == QW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == QW'(DEPTH-1)) ? '0 : rp + 1'b1;
      qn <= qn + (QW+1)'(push) - (QW+1)'(pop);

      if (resolve) begin
        beat_cnt   <= early_beat ? 9'd1 : 9'd0;
        early_done <= early_beat && w_last;
      end else if (ctx_beat) begin
        if (w_last) begin
          cur_valid <= 1'b0;
          beat_cnt  <= '0;
        end else begin
          cur_valid <= 1'b1;
          beat_cnt  <= beat_nxt;
          if (take_q) begin
            cur_len <= c_len; cur_lo <= c_lo; cur_size <= c_size; cur_burst <= c_burst;
          end
        end
      end else if (early_beat && !early_done) begin
        beat_cnt   <= beat_nxt;
        early_done <= w_last;
      end

      aw_ahead <= aw_ahead + CNT_W'(aw_inc) - CNT_W'(aw_dec);
      w_ahead  <= w_ahead + CNT_W'(wl_inc) - CNT_W'(wl_dec);

      w_hold    <= w_valid && !w_ready;
      b_hold    <= b_valid && !b_ready;
      first_cyc <= 1'b0;
      wd_q <= w_data; ws_q <= w_strb; wl_q <= w_last; wu_q <= w_user;
      bi_q <= b_id;   br_q <= b_resp; bu_q <= b_user;

      err_beats       <= cnt_bad_beat || cnt_bad_res;
      err_strobe      <= strb_bad;
      err_early_resp  <= b_start && (aw_ahead == '0 || w_ahead == '0);
      err_w_hold      <= w_hold && (!w_valid || w_moved);
      err_b_hold      <= b_hold && (!b_valid || b_moved);
      err_reset_valid <= first_cyc && (w_valid || b_valid);
      trk_overflow    <= trk_overflow || ovf_aw || ovf_w;
      trk_underflow   <= trk_underflow || (b_start && aw_ahead == '0);
    end
  end

  AST_LAST_TOO_SOON: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready && cur_valid && w_last && beat_cnt != {1'b0, cur_len}) |=> err_beats); // R1
  AST_LAST_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready && cur_valid && !w_last && beat_cnt == {1'b0, cur_len}) |=> err_beats); // R2
  AST_RESP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_hold && aw_ahead == '0) |=> (err_early_resp && trk_underflow)); // R12
  AST_W_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hold && !w_valid) |=> err_w_hold); // R8
  AST_B_RESP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hold && b_valid && b_resp != br_q) |=> err_b_hold); // R9
  AST_FIRST_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (first_cyc && (w_valid || b_valid)) |=> err_reset_valid); // R10
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    qn <= (QW+1)'(DEPTH)); // R11
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && q_full && !pop) |=> trk_overflow); // R11

endmodule

// File: tb/wr_order_monitor_tb.sv
`timescale 1ns/1ps
module wr_order_monitor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_valid = 0, aw_ready = 0;
  logic [1:0]  aw_addr_lo = 0;
  logic [7:0]  aw_len = 0;
  logic [2:0]  aw_size = 0;
  logic [1:0]  aw_burst = 0;
  logic        w_valid = 0, w_ready = 0, w_last = 0;
  logic [31:0] w_data = 0;
  logic [3:0]  w_strb = 0;
  logic [1:0]  w_user = 0;
  logic        b_valid = 0, b_ready = 0;
  logic [3:0]  b_id = 0;
  logic [1:0]  b_resp = 0;
  logic [1:0]  b_user = 0;
  logic err_beats, err_strobe, err_early_resp, err_w_hold, err_b_hold;
  logic err_reset_valid, trk_overflow, trk_underflow;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wr_order_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr_lo(aw_addr_lo),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
    .w_last(w_last), .w_user(w_user),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp), .b_user(b_user),
    .err_beats(err_beats), .err_strobe(err_strobe), .err_early_resp(err_early_resp),
    .err_w_hold(err_w_hold), .err_b_hold(err_b_hold), .err_reset_valid(err_reset_valid),
    .trk_overflow(trk_overflow), .trk_underflow(trk_underflow)
  );

  // {lo[1:0], size[2:0], burst[1:0], len[1:0], strobes beat0 in low nibble [15:0], expected strobe error per beat [3:0]}
  localparam logic [28:0] VEC [12] = '{
    {2'd0, 3'd2, 2'd1, 2'd1, 16'h00FF, 4'b0000},
    {2'd1, 3'd2, 2'd1, 2'd1, 16'h00FE, 4'b0000},
    {2'd1, 3'd2, 2'd1, 2'd1, 16'h00FF, 4'b0001},
    {2'd2, 3'd1, 2'd1, 2'd2, 16'h0C3C, 4'b0000},
    {2'd2, 3'd1, 2'd1, 2'd2, 16'h0CCC, 4'b0010},
    {2'd3, 3'd0, 2'd0, 2'd2, 16'h0488, 4'b0100},
    {2'd1, 3'd0, 2'd1, 2'd3, 16'h1842, 4'b0000},
    {2'd1, 3'd0, 2'd1, 2'd3, 16'h1822, 4'b0010},
    {2'd3, 3'd1, 2'd1, 2'd1, 16'h003C, 4'b0001},
    {2'd0, 3'd1, 2'd0, 2'd1, 16'h0033, 4'b0000},
    {2'd0, 3'd0, 2'd1, 2'd0, 16'h0000, 4'b0000},
    {2'd2, 3'd2, 2'd1, 2'd1, 16'h00FC, 4'b0000}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0; w_strb = 0;
    b_valid = 0; b_ready = 0; b_resp = 0; b_id = 0; b_user = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; clear_inputs();
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_aw(input logic [1:0] lo, input logic [7:0] len, input logic [2:0] sz, input logic [1:0] bt);
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_addr_lo = lo; aw_len = len; aw_size = sz; aw_burst = bt;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic send_w(input logic [3:0] s, input logic last);
    @(negedge clk);
    w_valid = 1; w_ready = 1; w_strb = s; w_last = last; w_data = w_data + 32'h11;
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic send_b();
    @(negedge clk);
    b_valid = 1; b_ready = 1; b_resp = 0;
    @(negedge clk);
    b_valid = 0; b_ready = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [28:0] e;
    int nb;
    string tg;
    repeat (2) @(negedge clk);
    chk("R13 err_beats in reset", err_beats, 0);
    chk("R13 overflow in reset", trk_overflow, 0);
    chk("R13 underflow in reset", trk_underflow, 0);
    // R10: response valid in first cycle after release
    rst_n = 1; b_valid = 1; b_ready = 1;
    @(negedge clk); b_valid = 0; b_ready = 0;
    chk("R10 b_valid first cycle", err_reset_valid, 1);
    do_reset();
    chk("R13 reset clears sticky underflow", trk_underflow, 0);
    chk("R13 no reset-valid after clean release", err_reset_valid, 0);
    chk("R13 err_strobe after reset", err_strobe, 0);
    // R10: data valid in first cycle after release
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1; w_valid = 1; w_ready = 1; w_last = 1; w_strb = 4'hF;
    @(negedge clk); w_valid = 0; w_ready = 0; w_last = 0;
    chk("R10 w_valid first cycle", err_reset_valid, 1);
    do_reset();

    // table of well-ordered bursts: strobe lanes R4 R5 R6
    for (int v = 0; v < 12; v++) begin
      e = VEC[v];
      nb = int'(e[21:20]);
      send_aw(e[28:27], {6'd0, e[21:20]}, e[26:24], e[23:22]);
      for (int k = 0; k <= nb; k++) begin
        send_w(e[4 + 4*k +: 4], k == nb);
        if (k == 0) tg = "R4";
        else if (e[23:22] == 2'd0) tg = "R6";
        else tg = "R5";
        chk($sformatf("%s vec %0d beat %0d strobe", tg, v, k), err_strobe, e[k]);
        chk($sformatf("R1 vec %0d beat %0d count clean", v, k), err_beats, 0);
      end
      send_b();
      chk($sformatf("R7 vec %0d ordered response", v), err_early_resp, 0);
    end

    // R1: last marker too early
    send_aw(2'd0, 8'd2, 3'd2, 2'd1);
    send_w(4'hF, 0); chk("R1 beat0", err_beats, 0);
    send_w(4'hF, 1); chk("R1 last at index 1 of len 2", err_beats, 1);
    send_b();
    // R2: last marker missing
    send_aw(2'd0, 8'd1, 3'd2, 2'd1);
    send_w(4'hF, 0); chk("R2 beat0", err_beats, 0);
    send_w(4'hF, 0); chk("R2 no last at final index", err_beats, 1);
    send_w(4'hF, 1); chk("R2 late last index 2", err_beats, 1);
    send_b();
    // R3: early burst, matching length
    send_w(4'hF, 0); chk("R3 early beat0", err_beats, 0);
    send_w(4'hF, 1); chk("R3 early last", err_beats, 0);
    send_aw(2'd0, 8'd1, 3'd2, 2'd1);
    @(negedge clk); chk("R3 early match resolved", err_beats, 0);
    send_b();
    // R3: early burst, wrong length
    send_w(4'hF, 0);
    send_w(4'hF, 1);
    send_aw(2'd0, 8'd2, 3'd2, 2'd1);
    @(negedge clk); chk("R3 early mismatch resolved", err_beats, 1);
    send_b();
    // R3: partial early burst continues at index 1
    send_w(4'hC, 0);
    send_aw(2'd2, 8'd1, 3'd1, 2'd1);
    send_w(4'hC, 1);
    chk("R3 continued beat count", err_beats, 0);
    chk("R3 continued strobe index 1", err_strobe, 1);
    send_b();
    chk("R7 after early bursts in order", err_early_resp, 0);

    // R7: address only, then response
    do_reset();
    send_aw(2'd0, 8'd0, 3'd2, 2'd1);
    send_b();
    chk("R7 response without last beat", err_early_resp, 1);
    chk("R12 address present no underflow", trk_underflow, 0);
    // R7: last beat and response in the same cycle
    do_reset();
    send_aw(2'd0, 8'd0, 3'd2, 2'd1);
    @(negedge clk);
    w_valid = 1; w_ready = 1; w_last = 1; w_strb = 4'hF; b_valid = 1; b_ready = 1;
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0; b_valid = 0; b_ready = 0;
    chk("R7 response with last in same cycle", err_early_resp, 1);
    // R12: data only, then response
    do_reset();
    send_w(4'hF, 1);
    send_b();
    chk("R7 response without address", err_early_resp, 1);
    chk("R12 underflow set", trk_underflow, 1);
    repeat (3) @(negedge clk);
    chk("R12 underflow sticky", trk_underflow, 1);

    // R8: data stall stability
    do_reset();
    @(negedge clk); w_valid = 1; w_ready = 0; w_data = 32'hA5A5_0001; w_strb = 4'hF; w_last = 1;
    @(negedge clk);
    @(negedge clk); chk("R8 stable stall", err_w_hold, 0);
    w_data = 32'h5A5A_0002;
    @(negedge clk); chk("R8 data changed in stall", err_w_hold, 1);
    w_ready = 1;
    @(negedge clk); chk("R8 accepted after stall", err_w_hold, 0);
    w_valid = 0; w_ready = 0; w_last = 0;
    @(negedge clk); w_valid = 1; w_ready = 0; w_last = 0;
    @(negedge clk); w_valid = 0;
    @(negedge clk); chk("R8 valid dropped in stall", err_w_hold, 1);

    // R9: response stall stability
    do_reset();
    @(negedge clk); b_valid = 1; b_ready = 0; b_resp = 2'd0;
    @(negedge clk);
    @(negedge clk); chk("R9 stable stall", err_b_hold, 0);
    b_resp = 2'd2;
    @(negedge clk); chk("R9 response code changed", err_b_hold, 1);
    b_valid = 0;
    @(negedge clk); chk("R9 valid dropped in stall", err_b_hold, 1);

    // R11: queue overflow
    do_reset();
    for (int i = 0; i < 4; i++) send_aw(2'd0, 8'd0, 3'd2, 2'd1);
    @(negedge clk); chk("R11 full queue no overflow", trk_overflow, 0);
    send_aw(2'd0, 8'd0, 3'd2, 2'd1);
    chk("R11 fifth address overflows", trk_overflow, 1);
    repeat (3) @(negedge clk);
    chk("R11 overflow sticky", trk_overflow, 1);
    do_reset();
    chk("R13 reset clears overflow", trk_overflow, 0);
    send_w(4'hF, 1);
    chk("R11 one early burst fits", trk_overflow, 0);
    send_w(4'hF, 1);
    chk("R11 second early burst overflows", trk_overflow, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule